// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single down-counting timer channel driven by a count-enable strobe (`tick_en`). One tick is one clock cycle in which `tick_en` is high. A configuration write selects one of six waveform behaviours: terminal-count interrupt, hardware-retriggerable one-shot, rate generator, square wave, software strobe and hardware strobe. A load strobe then supplies the initial count and starts the channel. The `gate` input either pauses counting or restarts it on a rising edge, depending on the mode.

The channel produces one output waveform, `tmr_out`. It also presents its live counter value on `cur_count`, which a separate bus-side block reads and latches. Counting is binary only. This block has no data stream: every pin is a plain control or status signal with no back-pressure. All state is registered on `clk`. The outputs reflect the state after each rising edge.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the channel runs in mode 3 with a count of 65536. `cur_count` reads 0 and `tmr_out` is high. The stored gate history equals the `GATE_RST` parameter, so a gate held at that level makes no edge.
- R2: A loaded value of 0 counts as 65536 ticks. In mode 0, `tmr_out` rises on the 65536th tick after the load.
- R3: Mode codes 6 and 7 on `cfg_mode` act exactly as codes 2 and 3.
- R4: Mode 0 (code 0): a load drives `tmr_out` low and restarts counting. `cur_count` drops by 1 per tick and wraps past 0. `tmr_out` goes high once N ticks have elapsed and stays high until the next load or configuration write.
- R5: Mode 1 (code 1): `tmr_out` is low from the load until N ticks have elapsed, then high. Gate level does not pause counting. A rising gate edge reloads the counter with N and drives `tmr_out` low again.
- R6: Mode 2 (code 2): `cur_count` runs N, N-1, …, 1 and then returns to N. `tmr_out` is low only while the count is 1, which is one tick per period.
- R7: Mode 3 (code 3): with the same count sequence as mode 2, `tmr_out` is high for the first (N+1)/2 ticks of each period, rounded down, and low for the rest.
- R8: Modes 4 and 5 (codes 4 and 5): `tmr_out` stays high except for exactly one tick, which starts when N ticks have elapsed. In mode 5 a rising gate edge restarts the count from N.
- R9: In modes 0, 2, 3 and 4, `gate` low suspends counting. A rising gate edge restarts the count from the latest loaded value in modes 1, 2, 3 and 5. In modes 0 and 4 a rising edge has no effect on the count.
- R10: A load in mode 2 or 3 while the channel is running leaves the current count alone. The new value takes effect at the next period reload.
- R11: A configuration write stops the channel and freezes `cur_count` until the next load. While stopped, `tmr_out` is low in mode 0 and high in every other mode.
- R12: When inputs coincide in one cycle, the order of precedence is: configuration write, then load, then gate restart, then tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable strobe; one tick per cycle when high |
| gate | input | 1 | Gate level (pause or retrigger, depending on mode) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code captured on `cfg_wr` |
| load | input | 1 | Count load strobe |
| load_val | input | 16 | Initial count captured on `load` (0 means 65536) |
| tmr_out | output | 1 | Channel output waveform |
| cur_count | output | 16 | Live counter value |

## Verification
The hardest state to reach from the ports is a period boundary in rate or square-wave mode that has a pending count waiting behind it. The stimulus loads a second value partway through a period and confirms that the count carries on undisturbed. It then ticks exactly up to the wrap and sees the new value appear. The full 65536-tick count is reached by holding `tick_en` high for 65535 cycles, checking that the output is still low, then giving one more tick. Coincident strobes are driven in a single cycle to expose the precedence order.

// File: rtl/itc_pkg.sv
package itc_pkg;

  typedef enum logic [2:0] {
    MD_TERM     = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } itc_mode_e;

  typedef enum logic [1:0] {
    PH_ARMED = 2'd0,
    PH_TERM  = 2'd1,
    PH_PAST  = 2'd2
  } itc_phase_e;

  // codes 6 and 7 fold onto the periodic modes
  function automatic itc_mode_e norm_mode(input logic [2:0] code);
    case (code)
      3'd6:    return MD_RATE;
      3'd7:    return MD_SQUARE;
      default: return itc_mode_e'(code);
    endcase
  endfunction

  function automatic logic is_periodic(input itc_mode_e m);
    return (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

  // modes whose counting stalls while gate is low
  function automatic logic is_gated(input itc_mode_e m);
    return (m == MD_TERM) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_SWSTROBE);
  endfunction

  // modes restarted by a rising gate edge
  function automatic logic is_retrig(input itc_mode_e m);
    return (m == MD_ONESHOT) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HWSTROBE);
  endfunction

endpackage

// File: rtl/itc_gate_ctl.sv
module itc_gate_ctl
  import itc_pkg::*;
#(
  parameter logic GATE_RST = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      gate,
  input  logic      tick_en,
  input  itc_mode_e mode,
  output logic      adv,
  output logic      trig
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= GATE_RST;
    else        gate_q <= gate;
  end

  always_comb begin
    trig = gate && !gate_q && is_retrig(mode);
    adv  = tick_en && (gate || !is_gated(mode));
  end
endmodule

// File: rtl/itc_count_core.sv
module itc_count_core
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_mode,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             adv,
  input  logic             trig,
  output itc_mode_e        mode_o,
  output logic             run_o,
  output itc_phase_e       phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W:0]   per_o,
  output logic [CNT_W-1:0] reload_o
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  itc_mode_e        mode_q;
  itc_phase_e       phase_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W:0]   per_q;

  function automatic logic [CNT_W:0] widen(input logic [CNT_W-1:0] v);
    return (v == '0) ? FULL : {1'b0, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_SQUARE;
      phase_q  <= PH_ARMED;
      run_q    <= 1'b1;
      cnt_q    <= '0;
      reload_q <= '0;
      per_q    <= FULL;
    end else if (cfg_wr) begin
      mode_q  <= norm_mode(cfg_mode);
      run_q   <= 1'b0;
      phase_q <= PH_ARMED;
    end else if (load) begin
      reload_q <= load_val;
      if (!run_q || !is_periodic(mode_q)) begin
        cnt_q   <= load_val;
        per_q   <= widen(load_val);
        phase_q <= PH_ARMED;
        run_q   <= 1'b1;
      end
    end else if (run_q && trig) begin
      cnt_q   <= reload_q;
      per_q   <= widen(reload_q);
      phase_q <= PH_ARMED;
    end else if (run_q && adv) begin
      if (is_periodic(mode_q)) begin
        if (cnt_q == ONE) begin
          cnt_q <= reload_q;
          per_q <= widen(reload_q);
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end else begin
        cnt_q <= cnt_q - ONE;
        case (phase_q)
          PH_ARMED: if (cnt_q == ONE) phase_q <= PH_TERM;
          PH_TERM:  phase_q <= PH_PAST;
          default:  phase_q <= phase_q;
        endcase
      end
    end
  end

  assign mode_o   = mode_q;
  assign run_o    = run_q;
  assign phase_o  = phase_q;
  assign cnt_o    = cnt_q;
  assign per_o    = per_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/itc_out_decode.sv
module itc_out_decode
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  itc_mode_e        mode,
  input  logic             run,
  input  itc_phase_e       phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W:0]   per,
  output logic             out
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] ONE_W = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W:0] cnt_w;

  always_comb begin
    cnt_w = (cnt == '0) ? FULL : {1'b0, cnt};
    if (!run) begin
      out = (mode != MD_TERM);
    end else begin
      case (mode)
        MD_TERM, MD_ONESHOT:       out = (phase != PH_ARMED);
        MD_RATE:                   out = (cnt_w != ONE_W);
        MD_SQUARE:                 out = (cnt_w > (per >> 1));
        MD_SWSTROBE, MD_HWSTROBE:  out = (phase != PH_TERM);
        default:                   out = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
  import itc_pkg::*;
#(
  parameter int   CNT_W    = 16,
  parameter logic GATE_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_mode,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             tmr_out,
  output logic [CNT_W-1:0] cur_count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  itc_mode_e        mode_w;
  itc_phase_e       phase_w;
  logic             run_w;
  logic             adv_w;
  logic             trig_w;
  logic [CNT_W:0]   per_w;
  logic [CNT_W-1:0] reload_w;

  itc_gate_ctl #(.GATE_RST(GATE_RST)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate    (gate),
    .tick_en (tick_en),
    .mode    (mode_w),
    .adv     (adv_w),
    .trig    (trig_w)
  );

  itc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_mode (cfg_mode),
    .load     (load),
    .load_val (load_val),
    .adv      (adv_w),
    .trig     (trig_w),
    .mode_o   (mode_w),
    .run_o    (run_w),
    .phase_o  (phase_w),
    .cnt_o    (cur_count),
    .per_o    (per_w),
    .reload_o (reload_w)
  );

  itc_out_decode #(.CNT_W(CNT_W)) u_dec (
    .mode  (mode_w),
    .run   (run_w),
    .phase (phase_w),
    .cnt   (cur_count),
    .per   (per_w),
    .out   (tmr_out)
  );

  AST_CFG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> $stable(cur_count)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_w && !load && !cfg_wr) |=> $stable(cur_count)); // R11
  AST_TERM_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MD_TERM && run_w && tmr_out && !load && !cfg_wr) |=> tmr_out); // R4
  AST_LOAD_DROPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MD_TERM && load && !cfg_wr) |=> !tmr_out); // R4
  AST_RATE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MD_RATE && run_w && !tmr_out && adv_w && !load && !cfg_wr && reload_w != ONE)
    |=> tmr_out); // R6
  AST_GATE_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && is_gated(mode_w) && !gate && !load && !cfg_wr) |=> $stable(cur_count)); // R9
endmodule

// File: tb/interval_timer_chan_bench.sv
module interval_timer_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic        load = 1'b0;
  logic [15:0] load_val = 16'd0;
  logic        tmr_out;
  logic [15:0] cur_count;
  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  interval_timer_chan u_interval_timer_chan (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .load(load), .load_val(load_val),
    .tmr_out(tmr_out), .cur_count(cur_count)
  );

  // {mode[2:0], count[15:0], ticks[7:0], exp_out, exp_count[15:0]}
  localparam logic [43:0] VEC [18] = '{
    {3'd0, 16'd5, 8'd4, 1'b0, 16'h0001},
    {3'd0, 16'd5, 8'd5, 1'b1, 16'h0000},
    {3'd0, 16'd5, 8'd8, 1'b1, 16'hFFFD},
    {3'd1, 16'd3, 8'd2, 1'b0, 16'h0001},
    {3'd1, 16'd3, 8'd3, 1'b1, 16'h0000},
    {3'd2, 16'd4, 8'd3, 1'b0, 16'h0001},
    {3'd2, 16'd4, 8'd4, 1'b1, 16'h0004},
    {3'd2, 16'd4, 8'd2, 1'b1, 16'h0002},
    {3'd3, 16'd5, 8'd2, 1'b1, 16'h0003},
    {3'd3, 16'd5, 8'd3, 1'b0, 16'h0002},
    {3'd3, 16'd5, 8'd5, 1'b1, 16'h0005},
    {3'd4, 16'd3, 8'd2, 1'b1, 16'h0001},
    {3'd4, 16'd3, 8'd3, 1'b0, 16'h0000},
    {3'd4, 16'd3, 8'd4, 1'b1, 16'hFFFF},
    {3'd5, 16'd3, 8'd3, 1'b0, 16'h0000},
    {3'd6, 16'd4, 8'd3, 1'b0, 16'h0001},
    {3'd7, 16'd4, 8'd2, 1'b0, 16'h0002},
    {3'd0, 16'd0, 8'd3, 1'b0, 16'hFFFD}
  };

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4, 3'd5: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] exp_cnt, input logic exp_o);
    checks++;
    if (cur_count !== exp_cnt || tmr_out !== exp_o) begin
      errors++;
      $display("FAIL %s count=%h exp=%h out=%b exp=%b", req, cur_count, exp_cnt, tmr_out, exp_o);
    end
  endtask

  task automatic cfg(input logic [2:0] m);
    @(negedge clk); cfg_wr = 1'b1; cfg_mode = m;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic ld(input logic [15:0] v);
    @(negedge clk); load = 1'b1; load_val = v;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk); gate = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 16'h0000, 1'b1);
    ticks(1);
    chk("R1 runs after reset", 16'hFFFF, 1'b1);

    for (int i = 0; i < 18; i++) begin
      cfg(VEC[i][43:41]);
      ld(VEC[i][40:25]);
      ticks(int'(VEC[i][24:17]));
      chk(tag_of(VEC[i][43:41]), VEC[i][15:0], VEC[i][16]);
    end

    // R11: configuration write idles the channel
    cfg(3'd0);
    ticks(3);
    chk("R11 idle freeze", 16'hFFFD, 1'b0);

    // R9: mode 0 pauses with gate low, rising edge does not restart
    set_gate(1'b0);
    ld(16'd5);
    ticks(3);
    chk("R9 mode0 paused", 16'd5, 1'b0);
    set_gate(1'b1);
    ticks(2);
    chk("R9 mode0 resume", 16'd3, 1'b0);

    // R5: mode 1 counts with gate low, rising edge retriggers
    cfg(3'd1);
    set_gate(1'b0);
    ld(16'd3);
    ticks(3);
    chk("R5 gate ignored", 16'd0, 1'b1);
    set_gate(1'b1);
    chk("R5 retrigger", 16'd3, 1'b0);

    // R8: mode 5 retrigger
    cfg(3'd5);
    ld(16'd3);
    ticks(2);
    chk("R8 before retrig", 16'd1, 1'b1);
    set_gate(1'b0);
    set_gate(1'b1);
    chk("R8 retrig", 16'd3, 1'b1);
    ticks(3);
    chk("R8 strobe", 16'd0, 1'b0);
    ticks(1);
    chk("R8 strobe ends", 16'hFFFF, 1'b1);

    // R10: new count in mode 2 waits for the reload
    cfg(3'd2);
    ld(16'd4);
    ticks(1);
    ld(16'd6);
    chk("R10 count kept", 16'd3, 1'b1);
    ticks(2);
    chk("R10 dip", 16'd1, 1'b0);
    ticks(1);
    chk("R10 new period", 16'd6, 1'b1);

    // R9: mode 3 pause and rising-edge restart
    cfg(3'd3);
    ld(16'd6);
    ticks(2);
    set_gate(1'b0);
    ticks(2);
    chk("R9 mode3 paused", 16'd4, 1'b1);
    set_gate(1'b1);
    chk("R9 mode3 restart", 16'd6, 1'b1);

    // R12: load beats tick; configuration write beats load
    cfg(3'd0);
    ld(16'd5);
    @(negedge clk); load = 1'b1; load_val = 16'd7; tick_en = 1'b1;
    @(negedge clk); load = 1'b0; tick_en = 1'b0;
    chk("R12 load over tick", 16'd7, 1'b0);
    @(negedge clk); cfg_wr = 1'b1; cfg_mode = 3'd4; load = 1'b1; load_val = 16'd9;
    @(negedge clk); cfg_wr = 1'b0; load = 1'b0;
    chk("R12 cfg over load", 16'd7, 1'b1);

    // R4: reload in mode 0 drops the output again
    cfg(3'd0);
    ld(16'd5);
    ticks(5);
    chk("R4 expired", 16'd0, 1'b1);
    ld(16'd2);
    chk("R4 reload", 16'd2, 1'b0);

    // R2: zero means 65536 ticks
    ld(16'd0);
    ticks(65535);
    chk("R2 one short", 16'd1, 1'b0);
    ticks(1);
    chk("R2 full count", 16'd0, 1'b1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog count=%h exp=done out=%b exp=done", cur_count, tmr_out);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule